// File: doc/BRIEF.md
# Step-Event Scheduled Loop Datapath

This block is the body of a pipelined loop that runs with no central state machine. An external loop counter presents an index and a one-cycle step event. Each step event captures the index and a data sample into a chain of registers. The event, the index and the sample then move down the chain together, one stage per clock. Every operation in the body is tied to a tap on that chain, so it fires a fixed number of cycles after the step that launched it. Its result register is written only when the delayed event reaches its tap.

The example body has two operations. The first keeps a running maximum of the samples. A comparison predicate decides which of two alternative writes updates the maximum register. The second computes the difference between a sample and the sample of the previous step event, and it reports the index that came with that sample. Each result comes with a valid flag, which is the delayed step event that caused the write. Step events may arrive on every cycle, and then one result per cycle comes out of each operation.

Top module: `loop_step_datapath`

## Requirements
- R1: While `rst_n` is low and on the first cycle after release, `max_o`, `diff_o` and `diff_idx_o` are zero and both valid flags are low.
- R2: A difference write sets `diff_idx_o` to the `idx_i` value sampled with the launching step event.
- R3: A step event sampled at clock edge n writes the maximum at edge n+MAX_AT and the difference at edge n+DIFF_AT (defaults 1 and 3), and at no other edge.
- R4: When a maximum write fires, the predicate (stored maximum < sample) selects the sample. When the predicate is false, the stored maximum is kept, and this includes equal values. Samples are unsigned.
- R5: The first maximum write after reset loads the sample whatever its value.
- R6: `diff_o` is the sample minus the sample of the previous step event, modulo 2^DATA_W. The previous sample is zero after reset.
- R7: Between their writes, `max_o`, `diff_o` and `diff_idx_o` hold their values.
- R8: `max_vld_o` and `diff_vld_o` are high for exactly the one cycle that follows each write of their result.
- R9: Step events on consecutive cycles produce valid results on consecutive cycles, with no stall.
- R10: Step events still in the chain when reset is asserted produce no write after reset.
- R11: While `step_i` is low, `idx_i` and `data_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_i | input | IDX_W | Loop index from the counter |
| step_i | input | 1 | Loop step event, one cycle per iteration |
| data_i | input | DATA_W | Sample for this iteration |
| max_o | output | DATA_W | Running maximum |
| max_vld_o | output | 1 | Maximum was written on the last edge |
| diff_o | output | DATA_W | Sample minus previous sample |
| diff_idx_o | output | IDX_W | Index that came with the difference sample |
| diff_vld_o | output | 1 | Difference was written on the last edge |

## Verification
The maximum write and the difference write can land on the same edge. This happens when they come from the same stream of back-to-back events, and also when two events spaced DIFF_AT-MAX_AT cycles apart make the later one's maximum fall on the earlier one's difference. The bench provokes both with dense bursts and with events exactly two cycles apart. It then compares both results, both flags and the index on every clock against a model that keeps a history of step events and applies each write at its own offset. A mid-stream reset with events in flight checks that the pending writes are discarded.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

    // depth of the event chain needed to reach the deeper of two taps
    function automatic int unsigned chain_depth(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/step_chain.sv
module step_chain #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              step_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic [DATA_W-1:0]                 data_i,
    output logic [DEPTH-1:0]                  tap_vld_o,
    output logic [DEPTH-1:0][IDX_W-1:0]       tap_idx_o,
    output logic [DEPTH-1:0][DATA_W-1:0]      tap_dat_o
);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][IDX_W-1:0]  idx;
        logic [DEPTH-1:0][DATA_W-1:0] dat;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.vld[0] = step_i;
        // index and sample are captured only with an event
        if (step_i) begin
            st_d.idx[0] = idx_i;
            st_d.dat[0] = data_i;
        end
        for (int j = 1; j < int'(DEPTH); j++) begin
            st_d.vld[j] = st_q.vld[j-1];
            st_d.idx[j] = st_q.idx[j-1];
            st_d.dat[j] = st_q.dat[j-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_vld_o = st_q.vld;
    assign tap_idx_o = st_q.idx;
    assign tap_dat_o = st_q.dat;

    // R2: an event carries its own index one stage further each clock
    generate
        for (genvar g = 1; g < int'(DEPTH); g++) begin : g_chk
            stage_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.vld[g-1] |=> (st_q.vld[g] && st_q.idx[g] == $past(st_q.idx[g-1])));
        end
    endgenerate

endmodule

// File: rtl/max_stage.sv
module max_stage #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] max_o,
    output logic              vld_o
);

    typedef struct packed {
        logic              seen;
        logic [DATA_W-1:0] best;
        logic              vld;
    } max_t;

    max_t st_d, st_q;
    logic take_new;

    always_comb begin
        // predicate chooses exactly one of two writes to best
        take_new = !st_q.seen || (st_q.best < sample_i);
        st_d     = st_q;
        st_d.vld = fire_i;
        if (fire_i) begin
            st_d.seen = 1'b1;
            if (take_new) st_d.best = sample_i;
            else          st_d.best = st_q.best;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign max_o = st_q.best;
    assign vld_o = st_q.vld;

    // R4
    max_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && st_q.seen) |=> (st_q.best >= $past(st_q.best)));
    // R7
    max_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(st_q.best));

endmodule

// File: rtl/diff_stage.sv
module diff_stage #(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] diff_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              vld_o
);

    typedef struct packed {
        logic [DATA_W-1:0] prev;
        logic [DATA_W-1:0] diff;
        logic [IDX_W-1:0]  idx;
        logic              vld;
    } diff_t;

    diff_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = fire_i;
        if (fire_i) begin
            st_d.diff = sample_i - st_q.prev;
            st_d.prev = sample_i;
            st_d.idx  = idx_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign diff_o = st_q.diff;
    assign idx_o  = st_q.idx;
    assign vld_o  = st_q.vld;

    // R7
    diff_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> ($stable(st_q.diff) && $stable(st_q.idx)));
    // R6
    diff_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> (st_q.prev == $past(st_q.prev) + st_q.diff));

endmodule

// File: rtl/loop_step_datapath.sv
module loop_step_datapath #(
    parameter int unsigned IDX_W   = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned MAX_AT  = 1,
    parameter int unsigned DIFF_AT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic              step_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] max_o,
    output logic              max_vld_o,
    output logic [DATA_W-1:0] diff_o,
    output logic [IDX_W-1:0]  diff_idx_o,
    output logic              diff_vld_o
);

    localparam int unsigned DEPTH = lsp_pkg::chain_depth(MAX_AT, DIFF_AT);

    logic [DEPTH-1:0]             tap_vld;
    logic [DEPTH-1:0][IDX_W-1:0]  tap_idx;
    logic [DEPTH-1:0][DATA_W-1:0] tap_dat;

    step_chain #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step_i),
        .idx_i     (idx_i),
        .data_i    (data_i),
        .tap_vld_o (tap_vld),
        .tap_idx_o (tap_idx),
        .tap_dat_o (tap_dat)
    );

    max_stage #(.DATA_W(DATA_W)) u_max (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (tap_vld[MAX_AT-1]),
        .sample_i (tap_dat[MAX_AT-1]),
        .max_o    (max_o),
        .vld_o    (max_vld_o)
    );

    diff_stage #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_diff (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (tap_vld[DIFF_AT-1]),
        .idx_i    (tap_idx[DIFF_AT-1]),
        .sample_i (tap_dat[DIFF_AT-1]),
        .diff_o   (diff_o),
        .idx_o    (diff_idx_o),
        .vld_o    (diff_vld_o)
    );

    // R8: a result can only be flagged if an event reached its tap
    max_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_vld[MAX_AT-1] |=> !max_vld_o);
    // R8
    diff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tap_vld[DIFF_AT-1] |=> !diff_vld_o);

endmodule

// File: tb/sim_loop_step_datapath.sv
module sim_loop_step_datapath;
    localparam int CLK_P   = 10;
    localparam int MAX_AT  = 1;
    localparam int DIFF_AT = 3;
    localparam int HLEN    = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0]  idx_i = '0;
    logic        step_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [15:0] max_o, diff_o;
    logic [7:0]  diff_idx_o;
    logic        max_vld_o, diff_vld_o;

    always #(CLK_P/2) clk = ~clk;

    loop_step_datapath #(.IDX_W(8), .DATA_W(16), .MAX_AT(MAX_AT), .DIFF_AT(DIFF_AT)) u0 (
        .clk(clk), .rst_n(rst_n), .idx_i(idx_i), .step_i(step_i), .data_i(data_i),
        .max_o(max_o), .max_vld_o(max_vld_o), .diff_o(diff_o),
        .diff_idx_o(diff_idx_o), .diff_vld_o(diff_vld_o)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // behavioural model: event history indexed by edge count
    bit          hs [HLEN];
    logic [7:0]  hi [HLEN];
    logic [15:0] hd [HLEN];
    int e = 0;
    int base = 0;
    bit m_seen = 0;
    logic [15:0] m_max = '0, m_prev = '0, m_diff = '0;
    logic [7:0]  m_idx = '0;
    bit m_mvld = 0, m_dvld = 0;
    int dvld_run = 0;
    int dvld_best = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seen = 0; m_max = '0; m_prev = '0; m_diff = '0; m_idx = '0;
            m_mvld = 0; m_dvld = 0; base = e;
        end else begin
            e = e + 1;
            hs[e] = step_i; hi[e] = idx_i; hd[e] = data_i;
            m_mvld = 0; m_dvld = 0;
            if (e - MAX_AT > base && hs[e-MAX_AT]) begin
                m_mvld = 1;
                if (!m_seen || m_max < hd[e-MAX_AT]) m_max = hd[e-MAX_AT];
                m_seen = 1;
            end
            if (e - DIFF_AT > base && hs[e-DIFF_AT]) begin
                m_dvld = 1;
                m_diff = hd[e-DIFF_AT] - m_prev;
                m_prev = hd[e-DIFF_AT];
                m_idx  = hi[e-DIFF_AT];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every output with the model, then drive the next inputs
    task automatic cyc(input bit st, input logic [7:0] ix, input logic [15:0] dv);
        @(negedge clk);
        chk(max_o == m_max, "R4/R5 max_o", max_o, m_max);
        chk(max_vld_o == m_mvld, "R3/R8 max_vld_o", max_vld_o, m_mvld);
        chk(diff_o == m_diff, "R6 diff_o", diff_o, m_diff);
        chk(diff_idx_o == m_idx, "R2 diff_idx_o", diff_idx_o, m_idx);
        chk(diff_vld_o == m_dvld, "R3/R8 diff_vld_o", diff_vld_o, m_dvld);
        if (diff_vld_o) dvld_run++; else dvld_run = 0;
        if (dvld_run > dvld_best) dvld_best = dvld_run;
        step_i = st; idx_i = ix; data_i = dv;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=1 expected=0");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] k;
        k = 0;
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk({max_o, diff_o, diff_idx_o, max_vld_o, diff_vld_o} == '0, "R1 reset outputs", max_o, 0);
        end
        rst_n = 1'b1;
        cyc(0, 0, 0);
        // R5 first load with small value, R3 sparse events
        cyc(1, k, 16'd5); k++;
        repeat (5) cyc(0, 8'hFF, 16'hFFFF);
        // R4 ascending, descending, equal
        cyc(1, k, 16'd9);  k++; repeat (4) cyc(0, 0, 0);
        cyc(1, k, 16'd3);  k++; repeat (4) cyc(0, 0, 0);
        cyc(1, k, 16'd9);  k++; repeat (4) cyc(0, 0, 0);
        // R6 wrap-around: smaller after larger
        cyc(1, k, 16'd1);  k++; repeat (4) cyc(0, 0, 0);
        // R11 idle with moving inputs, R7 hold
        for (int i = 0; i < 12; i++) cyc(0, 8'(i * 7), 16'(i * 4099));
        // both writes on one edge: events spaced DIFF_AT-MAX_AT apart
        for (int i = 0; i < 6; i++) begin
            cyc(1, k, 16'(100 + i * 13)); k++;
            cyc(0, 0, 0);
        end
        repeat (4) cyc(0, 0, 0);
        // R9 back-to-back burst
        dvld_best = 0;
        for (int i = 0; i < 20; i++) begin cyc(1, k, 16'(i * 311 + 7)); k++; end
        repeat (5) cyc(0, 0, 0);
        chk(dvld_best >= 20, "R9 consecutive diff valids", dvld_best, 20);
        // random traffic
        for (int i = 0; i < 300; i++) begin
            cyc(1'($urandom_range(0, 1)), 8'($urandom), 16'($urandom)); k++;
        end
        // R10 reset with events in flight
        cyc(1, 8'hA0, 16'h7777);
        cyc(1, 8'hA1, 16'h8888);
        @(negedge clk);
        rst_n = 1'b0; step_i = 0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cyc(0, 0, 0);
            chk(!max_vld_o && !diff_vld_o && max_o == 0 && diff_o == 0, "R10 no write after reset",
                {max_vld_o, diff_vld_o}, 0);
        end
        // R5 after reset: first sample loads even if zero-ish
        cyc(1, 8'h11, 16'd2);
        repeat (5) cyc(0, 0, 0);
        chk(max_o == 16'd2, "R5 reload after reset", max_o, 2);
        chk(diff_o == 16'd2 && diff_idx_o == 8'h11, "R6/R2 first diff after reset", diff_o, 2);
        finished = 1;
        summary();
        $finish;
    end
endmodule